// File: doc/BRIEF.md
# Priority Pipeline Stage Scheduler

This block hands work from six logical graphics stages to a small pool of shared cores. The stages, in pipeline order, are input assembly (stage id 0), vertex shading (1), primitive assembly (2), rasterization (3), pixel shading (4) and blend (5). Each stage owns a small task queue that is tracked as a count of waiting tasks plus a count of slots promised to tasks still running upstream. Any core can run any stage, so the mix of work on the cores follows the load.

On every cycle, each core that reports itself free is offered the highest-numbered stage that has a waiting task and room in the queue of the stage after it. Blend has no consumer and needs only a waiting task. The room in the consumer queue is claimed when the task is launched. The claim turns into a real queued entry when the core pulses completion for that task. Task execution itself is outside the block. A stage whose consumer is full is passed over, so a lower stage that can make progress runs instead.

External producers push tasks into any stage through a per-stage enqueue strobe. The per-stage waiting and reserved counts are visible on the ports so that producers can see the backpressure.

Top module: `prio_stage_sched`

## Requirements
- R1: After reset every stage's waiting count and reserved count is zero, and no core is launched.
- R2: An enqueue strobe for a stage is accepted only when that stage's waiting plus reserved count, as registered, is below the depth of 4. An accepted strobe raises the waiting count by one on the next cycle. A strobe into a full stage is ignored.
- R3: For every stage, the waiting count plus the reserved count never exceeds 4.
- R4: A core with core_free high launches in the same cycle whenever some stage is eligible, and launch_stage carries that stage's id (0 to 5, in the pipeline order above). A stage is eligible when its waiting count is non-zero and either it is stage 5 or its successor has room. The successor's room is 4 minus its waiting count, reserved count and any enqueue accepted in the same cycle.
- R5: Among the eligible stages, the one with the largest id is launched.
- R6: A stage whose successor has no room is skipped, and the next lower eligible stage is launched instead.
- R7: A launch lowers the source stage's waiting count by one on the next cycle. For stages 0 to 4 it also raises the successor's reserved count by one.
- R8: When both cores are free in the same cycle, core 0 chooses first. Core 1 then chooses using the counts left after core 0's launch and reservation. Core 1 never launches while core 0 is free and not launched.
- R9: A completion pulse on a core, with done_stage s below 5, moves one entry of stage s+1 from reserved to waiting on the next cycle. A completion with done_stage 5 changes no count.
- R10: A core whose core_free is low is never launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq | input | 6 | Per-stage enqueue strobe, bit s for stage s |
| core_free | input | NUM_CORES | Core c is idle and can take a task this cycle |
| done | input | NUM_CORES | Core c pulses completion of its task |
| done_stage | input | 3*NUM_CORES | Stage id of the task completing on core c, in bits 3c+2:3c |
| launch | output | NUM_CORES | Core c is given a task this cycle |
| launch_stage | output | 3*NUM_CORES | Stage id launched on core c, in bits 3c+2:3c |
| q_count | output | 6*CW | Waiting count of stage s, in bits CW*s+CW-1:CW*s |
| q_resv | output | 6*CW | Reserved count of stage s, in the same layout |

## Verification
The bench targets four situations. The first is a full stage receiving a further enqueue; a design that accepts it would break the capacity bound. The second is a stage held back only by reservations in its successor, not by waiting entries; a design that ignores reservations would launch the blocked stage instead of the lower ready one. The third is both cores free at once with a single eligible task or a single slot of room; a core 1 that does not see core 0's claim would double-launch or over-reserve. The fourth is a completion into a stage that is also receiving an enqueue and a reservation in the same cycle; it exposes count updates that are lost or applied twice. After a directed sequence, a long random phase drives legitimate completions for the tasks the block launched, and compares every launch and count against arithmetic expectations.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int STAGES = 6;
  localparam int SIDW   = 3;

  typedef enum logic [SIDW-1:0] {
    ST_INASM = 3'd0,
    ST_VERT  = 3'd1,
    ST_PRIM  = 3'd2,
    ST_RAST  = 3'd3,
    ST_PIX   = 3'd4,
    ST_BLEND = 3'd5
  } stage_e;
endpackage

// File: rtl/stage_queue.sv
module stage_queue #(
  parameter int DEPTH = 4,
  parameter int NC    = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NW   = $clog2(NC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [NW-1:0] take,
  input  logic [NW-1:0] reserve,
  input  logic [NW-1:0] commit,
  output logic [CW-1:0] count,
  output logic [CW-1:0] resv,
  output logic [CW-1:0] room
);
  int          used;
  logic        push_acc;
  logic        upd_en;
  logic [CW-1:0] count_nx, resv_nx;

  always_comb begin
    used     = int'(count) + int'(resv);
    push_acc = push_req && (used < DEPTH);
    room     = CW'(DEPTH - used - (push_acc ? 1 : 0));
    count_nx = CW'(int'(count) + (push_acc ? 1 : 0) - int'(take) + int'(commit));
    resv_nx  = CW'(int'(resv) + int'(reserve) - int'(commit));
    upd_en   = push_acc || (take != '0) || (reserve != '0) || (commit != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      resv  <= '0;
    end else if (upd_en) begin
      count <= count_nx;
      resv  <= resv_nx;
    end
  end
endmodule

// File: rtl/launch_arbiter.sv
module launch_arbiter #(
  parameter int NS = 6,
  parameter int NC = 2,
  parameter int CW = 3,
  parameter int NW = 2,
  parameter int SW = 3
) (
  input  logic [NS-1:0][CW-1:0] avail,
  input  logic [NS-2:0][CW-1:0] room_up,
  input  logic [NC-1:0]         core_free,
  output logic [NC-1:0]         grant,
  output logic [NC-1:0][SW-1:0] gstage,
  output logic [NS-1:0][NW-1:0] take
);
  int av [NS];
  int dn [NS];
  int tk [NS];

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      av[s] = int'(avail[s]);
      tk[s] = 0;
    end
    for (int s = 0; s < NS - 1; s++) dn[s] = int'(room_up[s]);
    dn[NS-1] = NC;
    grant  = '0;
    gstage = '0;
    for (int c = 0; c < NC; c++) begin
      logic found;
      found = 1'b0;
      if (core_free[c]) begin
        for (int s = NS - 1; s >= 0; s--) begin
          if (!found && av[s] > 0 && dn[s] > 0) begin
            found     = 1'b1;
            grant[c]  = 1'b1;
            gstage[c] = SW'(s);
            av[s]     = av[s] - 1;
            dn[s]     = dn[s] - 1;
            tk[s]     = tk[s] + 1;
          end
        end
      end
    end
    for (int s = 0; s < NS; s++) take[s] = NW'(tk[s]);
  end
endmodule

// File: rtl/prio_stage_sched.sv
module prio_stage_sched
  import sched_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int QDEPTH    = 4,
  localparam int NS = STAGES,
  localparam int SW = SIDW,
  localparam int CW = $clog2(QDEPTH + 1),
  localparam int NW = $clog2(NUM_CORES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NS-1:0]           enq,
  input  logic [NUM_CORES-1:0]    core_free,
  input  logic [NUM_CORES-1:0]    done,
  input  logic [NUM_CORES*SW-1:0] done_stage,
  output logic [NUM_CORES-1:0]    launch,
  output logic [NUM_CORES*SW-1:0] launch_stage,
  output logic [NS*CW-1:0]        q_count,
  output logic [NS*CW-1:0]        q_resv
);
  logic [NS-1:0][CW-1:0]        cnt, rsv, spc;
  logic [NS-1:0][NW-1:0]        tk, rv_in, cm;
  logic [NUM_CORES-1:0][SW-1:0] gst;

  // completions land in the stage after the one that finished
  always_comb begin
    cm = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int s = 1; s < NS; s++) begin
        if (done[c] && done_stage[c*SW +: SW] == SW'(s - 1)) cm[s] = cm[s] + NW'(1);
      end
    end
  end

  // each launch from stage s-1 claims one slot in stage s
  always_comb begin
    rv_in[0] = '0;
    for (int s = 1; s < NS; s++) rv_in[s] = tk[s-1];
  end

  genvar gs;
  generate
    for (gs = 0; gs < NS; gs++) begin : g_q
      stage_queue #(.DEPTH(QDEPTH), .NC(NUM_CORES)) u_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (enq[gs]),
        .take     (tk[gs]),
        .reserve  (rv_in[gs]),
        .commit   (cm[gs]),
        .count    (cnt[gs]),
        .resv     (rsv[gs]),
        .room     (spc[gs])
      );
    end
  endgenerate

  launch_arbiter #(.NS(NS), .NC(NUM_CORES), .CW(CW), .NW(NW), .SW(SW)) u_arb (
    .avail     (cnt),
    .room_up   (spc[NS-1:1]),
    .core_free (core_free),
    .grant     (launch),
    .gstage    (gst),
    .take      (tk)
  );

  assign launch_stage = gst;
  assign q_count      = cnt;
  assign q_resv       = rsv;

  logic unused_room0;
  assign unused_room0 = ^spc[0];
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int NC    = 2,
  parameter int DEPTH = 4,
  localparam int NS   = 6,
  localparam int SW   = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NC-1:0]    core_free,
  input logic [NC-1:0]    launch,
  input logic [NC*SW-1:0] launch_stage,
  input logic [NS*CW-1:0] q_count,
  input logic [NS*CW-1:0] q_resv
);
  genvar s, c;
  generate
    for (s = 0; s < NS; s++) begin : g_cap
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_count[s*CW +: CW]) + int'(q_resv[s*CW +: CW])) <= DEPTH);
    end
    for (c = 0; c < NC; c++) begin : g_core
      p_busy_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !core_free[c] |-> !launch[c]);
      p_stage_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch[c] |-> (launch_stage[c*SW +: SW] < SW'(NS)));
      p_src_waiting_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch[c] |-> (q_count[launch_stage[c*SW +: SW]*CW +: CW] != '0));
      p_sink_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (launch[c] && launch_stage[c*SW +: SW] < SW'(NS - 1)) |->
        ((int'(q_count[(launch_stage[c*SW +: SW] + 1)*CW +: CW]) +
          int'(q_resv[(launch_stage[c*SW +: SW] + 1)*CW +: CW])) < DEPTH));
    end
    if (NC >= 2) begin : g_ord
      p_core0_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_free[0] && launch[1]) |-> launch[0]);
    end
  endgenerate
endmodule

bind prio_stage_sched sched_checker #(.NC(NUM_CORES), .DEPTH(QDEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_free    (core_free),
  .launch       (launch),
  .launch_stage (launch_stage),
  .q_count      (q_count),
  .q_resv       (q_resv)
);

// File: tb/sim_prio_stage_sched.sv
module sim_prio_stage_sched;
  localparam int NC = 2;
  localparam int D  = 4;
  localparam int NS = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] enq;
  logic [NC-1:0] core_free, done;
  logic [NC*3-1:0] done_stage, launch_stage;
  logic [NC-1:0] launch;
  logic [NS*3-1:0] q_count, q_resv;

  int checks = 0;
  int fails  = 0;
  int mocc [NS];
  int mres [NS];
  bit busy [NC];
  logic [NC-1:0] last_l;
  int last_s [NC];

  always #5 clk = ~clk;

  prio_stage_sched #(.NUM_CORES(NC), .QDEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .enq(enq), .core_free(core_free), .done(done),
    .done_stage(done_stage), .launch(launch), .launch_stage(launch_stage),
    .q_count(q_count), .q_resv(q_resv)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic cycle(input logic [NS-1:0] e, input logic [NC-1:0] f,
                       input logic [NC-1:0] d, input int ds0, input int ds1);
    int acc [NS];
    int av [NS];
    int sp [NS];
    int tk [NS];
    @(negedge clk);
    enq = e; core_free = f; done = d;
    done_stage = {3'(ds1), 3'(ds0)};
    #2;
    for (int s = 0; s < NS; s++) begin
      acc[s] = (e[s] && (mocc[s] + mres[s] < D)) ? 1 : 0;
      sp[s]  = D - mocc[s] - mres[s] - acc[s];
      av[s]  = mocc[s];
      tk[s]  = 0;
    end
    for (int c = 0; c < NC; c++) begin
      bit fnd = 0;
      int es = 0;
      if (f[c]) begin
        for (int s = NS - 1; s >= 0; s--) begin
          if (!fnd && av[s] > 0 && (s == NS - 1 || sp[s+1] > 0)) begin
            fnd = 1; es = s; av[s]--; tk[s]++;
            if (s < NS - 1) sp[s+1]--;
          end
        end
      end
      last_l[c] = launch[c];
      last_s[c] = int'(launch_stage[c*3 +: 3]);
      if (!f[c]) chk("R10 launch on busy core", int'(launch[c]), 0);
      else chk(c == 0 ? "R4 launch core0" : "R8 launch core1", int'(launch[c]), int'(fnd));
      if (fnd && launch[c])
        chk(c == 0 ? "R5 stage core0" : "R8 stage core1", last_s[c], es);
    end
    for (int s = 0; s < NS; s++) begin
      mocc[s] += acc[s] - tk[s];
      if (s < NS - 1) mres[s+1] += tk[s];
    end
    if (d[0] && ds0 < NS - 1) begin mocc[ds0+1]++; mres[ds0+1]--; end
    if (d[1] && ds1 < NS - 1) begin mocc[ds1+1]++; mres[ds1+1]--; end
    @(posedge clk); #1;
    for (int s = 0; s < NS; s++) begin
      chk("R2 R7 R9 waiting count", int'(q_count[s*3 +: 3]), mocc[s]);
      chk("R7 R9 reserved count", int'(q_resv[s*3 +: 3]), mres[s]);
      checks++;
      if (int'(q_count[s*3 +: 3]) + int'(q_resv[s*3 +: 3]) > D) begin
        fails++;
        $display("FAIL R3 stage %0d: actual %0d expected <= %0d", s,
                 int'(q_count[s*3 +: 3]) + int'(q_resv[s*3 +: 3]), D);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enq = '0; core_free = '0; done = '0; done_stage = '0;
    for (int s = 0; s < NS; s++) begin mocc[s] = 0; mres[s] = 0; end
    for (int c = 0; c < NC; c++) busy[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 reset waiting", int'(q_count), 0);
    chk("R1 reset reserved", int'(q_resv), 0);
    chk("R1 reset launch", int'(launch), 0);
    cycle('0, 2'b11, '0, 0, 0);
    chk("R1 nothing to launch", int'(last_l), 0);

    for (int i = 0; i < 5; i++) cycle(6'b000001, '0, '0, 0, 0);
    chk("R2 full stage ignores push", int'(q_count[0 +: 3]), 4);
    for (int i = 0; i < 4; i++) cycle(6'b001000, '0, '0, 0, 0);
    for (int i = 0; i < 4; i++) cycle('0, 2'b01, '0, 0, 0);
    chk("R7 successor reserved", int'(q_resv[4*3 +: 3]), 4);
    chk("R7 source drained", int'(q_count[3*3 +: 3]), 0);
    cycle(6'b001100, '0, '0, 0, 0);
    cycle('0, 2'b01, '0, 0, 0);
    chk("R6 blocked stage skipped", last_s[0], 2);
    for (int i = 0; i < 4; i++) cycle('0, '0, 2'b01, 3, 0);
    chk("R9 reservation committed", int'(q_count[4*3 +: 3]), 4);
    chk("R9 reservation released", int'(q_resv[4*3 +: 3]), 0);
    cycle('0, '0, 2'b01, 2, 0);
    cycle('0, '0, 2'b01, 5, 0);
    chk("R9 blend completion no effect", int'(q_count), mocc[0] | (mocc[1] << 3) |
        (mocc[2] << 6) | (mocc[3] << 9) | (mocc[4] << 12) | (mocc[5] << 15));
    cycle('0, 2'b11, '0, 0, 0);
    for (int c = 0; c < NC; c++) if (last_l[c]) busy[c] = 1;
    for (int c = 0; c < NC; c++) last_s[c] = last_l[c] ? last_s[c] : 0;

    begin
      int bst [NC];
      for (int c = 0; c < NC; c++) bst[c] = busy[c] ? last_s[c] : 0;
      for (int n = 0; n < 3000; n++) begin
        logic [NS-1:0] e;
        logic [NC-1:0] f, d;
        e = NS'($urandom) & NS'($urandom);
        for (int c = 0; c < NC; c++) begin
          d[c] = busy[c] && ($urandom % 3 == 0);
          f[c] = !busy[c] && ($urandom % 4 != 0);
        end
        cycle(e, f, d, bst[0], bst[1]);
        for (int c = 0; c < NC; c++) begin
          if (d[c]) busy[c] = 0;
          if (f[c] && last_l[c]) begin busy[c] = 1; bst[c] = last_s[c]; end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule